// File: doc/BRIEF.md
# Tape Operation Frame Counter and Sequencer

This block runs the frame counter of a tape formatter and decides when a write, read or space operation ends, and how. For a write or a space, the host first loads the two's complement of the number of characters to write or records to skip. Each counted event then increments the counter, and the operation ends normally when the counter rolls over to zero. For a read, the counter is cleared when the command is accepted. It then counts the incoming characters, so when the record ends it holds the record length.

The block takes several inputs from the tape side: character strobes, record-detected strobes, tape-mark detection, and the load-point and end-of-tape levels. A one-second tick drives a watchdog. A space can stop early on a tape mark or at a tape end. Commands that cannot run are refused before any motion starts. Completion is shown by a one-cycle done pulse, a set of sticky error flags and an attention request. Motor control and the data path are outside this block.

Top module: `tape_op_sequencer`

## Requirements
- R1: For a write (code 0), each `char_strobe` while busy adds one to the counter. When the counter rolls from 0xFFFF to 0x0000, `busy` drops and the counter reads zero.
- R2: For a forward space (code 3) or reverse space (code 4), each `rec_strobe` adds one to the counter. Rolling over to zero ends the operation and sets `attn`.
- R3: For a forward read (code 1) or reverse read (code 2), an accepted command clears the counter. Each `char_strobe` adds one. A `rec_strobe` ends the read with the character count held, and `attn` stays clear.
- R4: A host load (`cnt_wr_en`) is applied only while `busy` is low. While busy it has no effect on `cnt_value`, and `cnt_value` can be read at any time.
- R5: A forward space ends early on `tape_mark` or `at_eot`. A reverse space ends early on `tape_mark` or `at_bot`.
- R6: When a space ends, `err_fc` is set if the counter is nonzero and cleared if it is zero.
- R7: If TIMEOUT_TICKS (default 7) ticks of `tick_1s` pass with no `rec_strobe` since the command or the last record, the operation ends with `err_incomplete` set. A reverse read or reverse space that reaches `at_bot` also ends with `err_incomplete` set.
- R8: The following commands are refused: a reverse read or reverse space issued while `at_bot` is high, and a write issued while `write_protect` is high. A refused command leaves `busy` low and sets `err_nonexec` and `attn`.
- R9: A write issued with `nrzi_mode` high is refused as in R8 when the loaded counter is nonzero and its negation is below MIN_NRZI_LEN (default 13). The same count is accepted with `nrzi_mode` low.
- R10: Completion is a one-cycle `op_done` pulse with `busy` low. After it, the counter holds its value. An accepted command clears `err_nonexec`, `err_fc`, `err_incomplete` and `attn`.
- R11: After reset, `cnt_value` is zero and `busy`, `op_done`, all error flags and `attn` are low.
- R12: Command codes 5 to 7 are ignored. They start nothing and change neither the counter nor any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_wr_en | input | 1 | Host load strobe for the counter |
| cnt_wr_data | input | 16 | Value to load |
| cnt_value | output | 16 | Current counter value |
| cmd_valid | input | 1 | Command strobe (GO) |
| cmd_code | input | 3 | Operation code, see R1 to R3 and R12 |
| nrzi_mode | input | 1 | High selects the low-density format with its minimum record length |
| write_protect | input | 1 | Selected unit is write protected |
| at_bot | input | 1 | Tape at load point |
| at_eot | input | 1 | Tape past end marker |
| char_strobe | input | 1 | One character written or read |
| rec_strobe | input | 1 | End of a record detected |
| tape_mark | input | 1 | Tape mark detected |
| tick_1s | input | 1 | One-cycle pulse once per second |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle completion pulse |
| err_nonexec | output | 1 | Command refused |
| err_fc | output | 1 | Space ended with counter nonzero |
| err_incomplete | output | 1 | Watchdog expired or load point reached in reverse |
| attn | output | 1 | Attention request |

## Verification
A wrong increment source or a missed clear shows in `cnt_value` one cycle after the offending strobe or command, and again in the length of every following operation. A faulty end decision is visible at the completion point. It shows as an `op_done` pulse that comes a cycle early or late, or never comes, or as `busy` staying high. A wrong flag update shows in `err_fc`, `err_incomplete` or `attn` in the cycle after completion. A refusal that wrongly starts motion raises `busy` one cycle after the command.

// File: rtl/tape_seq_pkg.sv
package tape_seq_pkg;
  localparam int FC_W = 16;
  typedef logic [FC_W-1:0] fc_t;

  typedef enum logic [2:0] {
    OP_WRITE   = 3'd0,
    OP_READ_F  = 3'd1,
    OP_READ_R  = 3'd2,
    OP_SPACE_F = 3'd3,
    OP_SPACE_R = 3'd4
  } op_e;

  function automatic logic op_known(logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic op_reverse(op_e o);
    return (o == OP_READ_R) || (o == OP_SPACE_R);
  endfunction

  function automatic logic op_space(op_e o);
    return (o == OP_SPACE_F) || (o == OP_SPACE_R);
  endfunction

  function automatic logic op_read(op_e o);
    return (o == OP_READ_F) || (o == OP_READ_R);
  endfunction

  // counter value after an optional increment
  function automatic fc_t fc_step(fc_t q, logic inc);
    return q + fc_t'(inc);
  endfunction

  // preload q encodes -len; zero means a full 2**FC_W span
  function automatic logic fc_short(fc_t q, int unsigned min_len);
    fc_t len;
    len = fc_t'(0) - q;
    return (q != '0) && (32'(len) < min_len);
  endfunction
endpackage

// File: rtl/tape_fc_counter.sv
module tape_fc_counter
  import tape_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load_en,
  input  fc_t  load_val,
  input  logic inc,
  output fc_t  q,
  output logic wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (clear)   q <= '0;
    else if (load_en) q <= load_val;
    else if (inc)     q <= fc_step(q, 1'b1);
  end

  assign wrap = inc && (fc_step(q, 1'b1) == '0);
endmodule

// File: rtl/tape_watchdog.sv
module tape_watchdog #(
  parameter int LIMIT = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (clear)       cnt <= '0;
    else if (run && tick) cnt <= cnt + 1'b1;
  end

  // fires on the tick that would reach LIMIT
  assign expire = run && tick && !clear && (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/tape_op_ctrl.sv
module tape_op_ctrl
  import tape_seq_pkg::*;
#(
  parameter int unsigned MIN_REC = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       cnt_wr_en,
  input  fc_t        cnt_q,
  input  logic       wrap,
  input  logic       nrzi_mode,
  input  logic       write_protect,
  input  logic       at_bot,
  input  logic       at_eot,
  input  logic       char_strobe,
  input  logic       rec_strobe,
  input  logic       tape_mark,
  input  logic       wd_expire,
  output logic       busy,
  output op_e        op_q,
  output logic       accept,
  output logic       reject,
  output logic       finish,
  output logic       cnt_inc,
  output logic       cnt_clear,
  output logic       cnt_load,
  output logic       wd_clear,
  output logic       op_done,
  output logic       err_nonexec,
  output logic       err_fc,
  output logic       err_incomplete,
  output logic       attn
);
  op_e  cmd_op;
  logic legal, rej_cond;
  logic end_count, end_rec, end_mark, hit_bot;
  fc_t  fc_after;

  assign cmd_op   = op_e'(cmd_code);
  assign legal    = cmd_valid && !busy && op_known(cmd_code);
  assign rej_cond = (op_reverse(cmd_op) && at_bot)
                 || ((cmd_op == OP_WRITE)
                     && (write_protect || (nrzi_mode && fc_short(cnt_q, MIN_REC))));
  assign accept   = legal && !rej_cond;
  assign reject   = legal && rej_cond;

  assign cnt_inc   = busy && (op_space(op_q) ? rec_strobe : char_strobe);
  assign fc_after  = fc_step(cnt_q, cnt_inc);
  assign end_count = busy && wrap && ((op_q == OP_WRITE) || op_space(op_q));
  assign end_rec   = busy && op_read(op_q) && rec_strobe;
  assign end_mark  = busy && op_space(op_q)
                  && (tape_mark || ((op_q == OP_SPACE_F) && at_eot)
                                || ((op_q == OP_SPACE_R) && at_bot));
  assign hit_bot   = busy && op_reverse(op_q) && at_bot;
  assign finish    = end_count || end_rec || end_mark || hit_bot || wd_expire;

  assign cnt_clear = accept && op_read(cmd_op);
  assign cnt_load  = cnt_wr_en && !busy && !cmd_valid;
  assign wd_clear  = accept || (busy && rec_strobe);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy           <= 1'b0;
      op_q           <= OP_WRITE;
      op_done        <= 1'b0;
      err_nonexec    <= 1'b0;
      err_fc         <= 1'b0;
      err_incomplete <= 1'b0;
      attn           <= 1'b0;
    end else begin
      op_done <= finish;
      if (accept) begin
        busy           <= 1'b1;
        op_q           <= cmd_op;
        err_nonexec    <= 1'b0;
        err_fc         <= 1'b0;
        err_incomplete <= 1'b0;
        attn           <= 1'b0;
      end else if (reject) begin
        err_nonexec <= 1'b1;
        attn        <= 1'b1;
      end else if (finish) begin
        busy <= 1'b0;
        if (hit_bot || wd_expire) err_incomplete <= 1'b1;
        if (op_space(op_q)) begin
          attn   <= 1'b1;
          err_fc <= (fc_after != '0);
        end
      end
    end
  end
endmodule

// File: rtl/tape_op_sequencer.sv
module tape_op_sequencer
  import tape_seq_pkg::*;
#(
  parameter int          TIMEOUT_TICKS = 7,
  parameter int unsigned MIN_NRZI_LEN  = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnt_wr_en,
  input  logic [15:0] cnt_wr_data,
  output logic [15:0] cnt_value,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_code,
  input  logic        nrzi_mode,
  input  logic        write_protect,
  input  logic        at_bot,
  input  logic        at_eot,
  input  logic        char_strobe,
  input  logic        rec_strobe,
  input  logic        tape_mark,
  input  logic        tick_1s,
  output logic        busy,
  output logic        op_done,
  output logic        err_nonexec,
  output logic        err_fc,
  output logic        err_incomplete,
  output logic        attn
);
  // internal events, named for the checker
  fc_t        cnt_q;
  logic       wrap, cnt_inc, cnt_clear, cnt_load;
  logic       wd_clear, wd_expire;
  logic       accept, reject, finish;
  op_e        op_q;
  logic [2:0] op_cur;

  assign cnt_value = cnt_q;
  assign op_cur    = op_q;

  tape_fc_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cnt_clear),
    .load_en  (cnt_load),
    .load_val (cnt_wr_data),
    .inc      (cnt_inc),
    .q        (cnt_q),
    .wrap     (wrap)
  );

  tape_watchdog #(.LIMIT(TIMEOUT_TICKS)) u_wd (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (wd_clear),
    .run    (busy),
    .tick   (tick_1s),
    .expire (wd_expire)
  );

  tape_op_ctrl #(.MIN_REC(MIN_NRZI_LEN)) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_code       (cmd_code),
    .cnt_wr_en      (cnt_wr_en),
    .cnt_q          (cnt_q),
    .wrap           (wrap),
    .nrzi_mode      (nrzi_mode),
    .write_protect  (write_protect),
    .at_bot         (at_bot),
    .at_eot         (at_eot),
    .char_strobe    (char_strobe),
    .rec_strobe     (rec_strobe),
    .tape_mark      (tape_mark),
    .wd_expire      (wd_expire),
    .busy           (busy),
    .op_q           (op_q),
    .accept         (accept),
    .reject         (reject),
    .finish         (finish),
    .cnt_inc        (cnt_inc),
    .cnt_clear      (cnt_clear),
    .cnt_load       (cnt_load),
    .wd_clear       (wd_clear),
    .op_done        (op_done),
    .err_nonexec    (err_nonexec),
    .err_fc         (err_fc),
    .err_incomplete (err_incomplete),
    .attn           (attn)
  );
endmodule

// File: rtl/tape_op_sequencer_chk.sv
module tape_op_sequencer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        op_done,
  input logic        err_nonexec,
  input logic        err_fc,
  input logic        err_incomplete,
  input logic        attn,
  input logic [15:0] cnt_value,
  input logic        cnt_wr_en,
  input logic        cmd_valid,
  input logic [2:0]  cmd_code,
  input logic        char_strobe,
  input logic        rec_strobe,
  input logic        accept,
  input logic        reject,
  input logic        finish,
  input logic [2:0]  op_cur
);
  logic is_space;
  assign is_space = (op_cur == 3'd3) || (op_cur == 3'd4);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |-> !busy);
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cnt_wr_en && !cmd_valid) |=> $stable(cnt_value));
  p_busy_no_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !char_strobe && !rec_strobe) |=> $stable(cnt_value));
  p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ((cmd_code == 3'd1) || (cmd_code == 3'd2))) |=> (cnt_value == 16'd0));
  p_reject_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> (!busy && err_nonexec));
  p_space_fc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && is_space) |=> (err_fc == (cnt_value != 16'd0)));
  p_write_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && (op_cur == 3'd0) && !err_incomplete) |-> (cnt_value == 16'd0));
  p_space_attn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && is_space) |-> attn);
endmodule

bind tape_op_sequencer tape_op_sequencer_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy           (busy),
  .op_done        (op_done),
  .err_nonexec    (err_nonexec),
  .err_fc         (err_fc),
  .err_incomplete (err_incomplete),
  .attn           (attn),
  .cnt_value      (cnt_value),
  .cnt_wr_en      (cnt_wr_en),
  .cmd_valid      (cmd_valid),
  .cmd_code       (cmd_code),
  .char_strobe    (char_strobe),
  .rec_strobe     (rec_strobe),
  .accept         (accept),
  .reject         (reject),
  .finish         (finish),
  .op_cur         (op_cur)
);

// File: tb/tape_op_sequencer_tb.sv
module tape_op_sequencer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_wr_en = 1'b0;
  logic [15:0] cnt_wr_data = '0;
  logic [15:0] cnt_value;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_code = '0;
  logic        nrzi_mode = 1'b0, write_protect = 1'b0;
  logic        at_bot = 1'b0, at_eot = 1'b0;
  logic        char_strobe = 1'b0, rec_strobe = 1'b0, tape_mark = 1'b0, tick_1s = 1'b0;
  logic        busy, op_done, err_nonexec, err_fc, err_incomplete, attn;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tape_op_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
    .cnt_value(cnt_value), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .nrzi_mode(nrzi_mode), .write_protect(write_protect), .at_bot(at_bot),
    .at_eot(at_eot), .char_strobe(char_strobe), .rec_strobe(rec_strobe),
    .tape_mark(tape_mark), .tick_1s(tick_1s), .busy(busy), .op_done(op_done),
    .err_nonexec(err_nonexec), .err_fc(err_fc), .err_incomplete(err_incomplete),
    .attn(attn)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic host_load(logic [15:0] v);
    cnt_wr_en = 1'b1; cnt_wr_data = v; cyc(); cnt_wr_en = 1'b0;
  endtask

  task automatic issue(logic [2:0] code);
    cmd_valid = 1'b1; cmd_code = code; cyc(); cmd_valid = 1'b0;
  endtask

  task automatic chars(int n);
    for (int i = 0; i < n; i++) begin char_strobe = 1'b1; cyc(); end
    char_strobe = 1'b0;
  endtask

  task automatic recs(int n);
    for (int i = 0; i < n; i++) begin rec_strobe = 1'b1; cyc(); end
    rec_strobe = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick_1s = 1'b1; cyc(); end
    tick_1s = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 cnt", cnt_value, 0);
    chk("R11 busy", busy, 0);
    chk("R11 done", op_done, 0);
    chk("R11 flags", {err_nonexec, err_fc, err_incomplete, attn}, 0);
  endtask

  task automatic t_write_pe();
    host_load(16'hFFFB);
    issue(3'd0);
    chk("R12 write start busy", busy, 1);
    chars(1);
    host_load(16'h1234);
    chk("R4 load ignored while busy", cnt_value, 16'hFFFC);
    chars(3);
    chk("R1 count", cnt_value, 16'hFFFF);
    chk("R1 still busy", busy, 1);
    chars(1);
    chk("R1 done", op_done, 1);
    chk("R1 busy low", busy, 0);
    chk("R1 rolled to zero", cnt_value, 0);
    chk("R1 no attn", attn, 0);
    cyc();
    chk("R10 single pulse", op_done, 0);
  endtask

  task automatic t_nrzi_short();
    nrzi_mode = 1'b1;
    host_load(16'hFFF4);
    issue(3'd0);
    chk("R9 short refused busy", busy, 0);
    chk("R9 nonexec", err_nonexec, 1);
    chk("R9 attn", attn, 1);
    chk("R9 cnt kept", cnt_value, 16'hFFF4);
    nrzi_mode = 1'b0;
    issue(3'd0);
    chk("R9 same count accepted in PE", busy, 1);
    chk("R10 flags cleared on accept", {err_nonexec, attn}, 0);
    chars(12);
    chk("R9 PE write done", op_done, 1);
    nrzi_mode = 1'b1;
    host_load(16'hFFF3);
    issue(3'd0);
    chk("R9 minimum accepted", busy, 1);
    chars(13);
    chk("R9 minimum write done", op_done, 1);
    chk("R1 zero after 13", cnt_value, 0);
    nrzi_mode = 1'b0;
  endtask

  task automatic t_protect();
    write_protect = 1'b1;
    host_load(16'hFFF0);
    issue(3'd0);
    chk("R8 protected busy", busy, 0);
    chk("R8 protected nonexec", err_nonexec, 1);
    chk("R8 cnt kept", cnt_value, 16'hFFF0);
    write_protect = 1'b0;
  endtask

  task automatic t_space_normal();
    host_load(16'hFFFD);
    issue(3'd3);
    chk("R2 busy", busy, 1);
    recs(2);
    chk("R2 count", cnt_value, 16'hFFFF);
    recs(1);
    chk("R2 done", op_done, 1);
    chk("R2 attn", attn, 1);
    chk("R6 no fc err", err_fc, 0);
    chk("R2 zero", cnt_value, 0);
  endtask

  task automatic t_space_mark();
    host_load(16'hFFFB);
    issue(3'd3);
    recs(2);
    tape_mark = 1'b1; cyc(); tape_mark = 1'b0;
    chk("R5 mark ends space", op_done, 1);
    chk("R5 busy low", busy, 0);
    chk("R6 fc err", err_fc, 1);
    chk("R6 count held", cnt_value, 16'hFFFD);
    cyc();
    chk("R10 hold after done", cnt_value, 16'hFFFD);
  endtask

  task automatic t_space_eot();
    host_load(16'hFFFC);
    issue(3'd3);
    recs(1);
    at_eot = 1'b1; cyc(); at_eot = 1'b0;
    chk("R5 eot ends fwd space", op_done, 1);
    chk("R6 fc err eot", err_fc, 1);
    chk("R5 cnt eot", cnt_value, 16'hFFFD);
  endtask

  task automatic t_reverse_at_bot();
    at_bot = 1'b1;
    host_load(16'hFFFE);
    issue(3'd4);
    chk("R8 rev space at bot busy", busy, 0);
    chk("R8 rev space nonexec", err_nonexec, 1);
    issue(3'd2);
    chk("R8 rev read at bot busy", busy, 0);
    chk("R8 rev read keeps cnt", cnt_value, 16'hFFFE);
    at_bot = 1'b0;
  endtask

  task automatic t_space_rev_bot();
    host_load(16'hFFFD);
    issue(3'd4);
    recs(1);
    at_bot = 1'b1; cyc(); at_bot = 1'b0;
    chk("R5 bot ends rev space", op_done, 1);
    chk("R7 incomplete at bot", err_incomplete, 1);
    chk("R6 fc err rev", err_fc, 1);
    chk("R5 cnt rev", cnt_value, 16'hFFFE);
  endtask

  task automatic t_read();
    host_load(16'h1234);
    issue(3'd1);
    chk("R3 cleared", cnt_value, 0);
    chars(6);
    chk("R3 counting", cnt_value, 6);
    chk("R3 busy", busy, 1);
    recs(1);
    chk("R3 done", op_done, 1);
    chk("R3 length held", cnt_value, 6);
    chk("R3 no attn", attn, 0);
    cyc(); cyc(); cyc();
    chk("R10 read hold", cnt_value, 6);
  endtask

  task automatic t_watchdog();
    host_load(16'hFFFE);
    issue(3'd3);
    ticks(6);
    chk("R7 not yet", busy, 1);
    recs(1);
    chk("R7 record restarts timer", cnt_value, 16'hFFFF);
    ticks(6);
    chk("R7 six ticks busy", busy, 1);
    ticks(1);
    chk("R7 expiry done", op_done, 1);
    chk("R7 incomplete", err_incomplete, 1);
    chk("R6 fc err on timeout", err_fc, 1);
  endtask

  task automatic t_illegal();
    issue(3'd5);
    chk("R12 code5 no start", busy, 0);
    issue(3'd7);
    chk("R12 code7 no start", busy, 0);
    chk("R12 cnt kept", cnt_value, 16'hFFFF);
    chk("R12 flags kept", {err_nonexec, err_fc, err_incomplete, attn}, 4'b0111);
  endtask

  task automatic t_read_rev_bot();
    issue(3'd2);
    chk("R3 rev read cleared", cnt_value, 0);
    chars(2);
    at_bot = 1'b1; cyc(); at_bot = 1'b0;
    chk("R7 rev read ends at bot", op_done, 1);
    chk("R7 rev read incomplete", err_incomplete, 1);
    chk("R3 rev read length", cnt_value, 2);
    chk("R3 rev read no attn", attn, 0);
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_write_pe();
    t_nrzi_short();
    t_protect();
    t_space_normal();
    t_space_mark();
    t_space_eot();
    t_reverse_at_bot();
    t_space_rev_bot();
    t_read();
    t_watchdog();
    t_illegal();
    t_read_rev_bot();
    cyc();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule